// File: doc/BRIEF.md
# ATA Taskfile Write Sequencer

This block turns a 16-byte bridge command block, already parsed out of its transport packet, into the short run of register writes that starts a command on an ATA drive. It drives a single-beat register port: a 3-bit register offset, a data byte and a one-cycle write strobe, gated by a ready input from the bus interface.

When a start pulse arrives, the block takes a copy of the command block and checks it. It checks the block-size code and the reserved control bits. An illegal block makes it report failure without any bus activity. A read-only request is handed over to the readback logic. A valid block produces a fixed, parameter-free write order. Features comes first. The high-order bytes of the 48-bit registers follow when enabled, then the low-order bytes, and the command register comes last. A device/head write goes at the front or the back of the run, as a flag selects. The device/head value comes either from the command block or from a bridge-supplied input.

Top module: `ata_tf_seq`

## Requirements
- R1: Bits 7:4 of command byte 4 hold log2 of sectors per block. A value above 8 produces a one-cycle `fail` pulse and no write strobe for that command.
- R2: Bits 3:1 of command byte 4 are reserved. Any of them set produces a one-cycle `fail` pulse and no write strobe. A fault under R1 or R2 takes precedence over R3.
- R3: Bit 0 of command byte 3 set on an otherwise legal block produces a one-cycle `handoff` pulse and no write strobe.
- R4: A legal write command first writes byte 6 to offset 1 (features). It then writes bytes 11..14 to offsets 2, 3, 4, 5 (count, LBA low, mid, high) and writes byte 15 to offset 7 (command) last among these. No other offset is written apart from device/head.
- R5: Bit 0 of command byte 4 set inserts writes of bytes 7..10 to offsets 2, 3, 4, 5, directly after features and before the low-order writes. When the bit is clear those bytes are never written.
- R6: Bit 1 of command byte 3 selects where the device/head write (offset 6) goes. When the bit is clear it is the very first write. When the bit is set it is the very last write, after the command write.
- R7: The device/head data is command byte 5 when bit 6 of command byte 2 is set, and `own_devhead` (sampled at start) otherwise.
- R8: Each strobe lasts exactly one cycle. A strobe is issued only after a cycle in which `bus_rdy` was high, and no strobe occurs while `bus_rdy` stays low.
- R9: Each accepted command ends in exactly one one-cycle pulse on exactly one of `done`, `fail` or `handoff`. `done` follows the final write, and no write follows `done`.
- R10: The command block is captured at the accepted start. A `start` pulse while a command is in progress is ignored.
- R11: During and right after reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run the command block |
| cmd_blk | input | 128 | Command block, byte k at bits 8k+7:8k |
| own_devhead | input | 8 | Bridge-supplied device/head value |
| bus_rdy | input | 1 | Register port can take a write |
| bus_addr | output | 3 | Register offset of the current write |
| bus_data | output | 8 | Data of the current write |
| bus_wr | output | 1 | One-cycle write strobe |
| done | output | 1 | Write run finished |
| fail | output | 1 | Command rejected, nothing written |
| handoff | output | 1 | Read-only request passed to readback |

## Verification
The bench uses random command blocks with a fixed seed, biased toward legal block-size codes. Every combination of the 48-bit, device-placement and device-source flags therefore shows up, and each combination gives its own expected write list, so a swapped byte, a misplaced device/head write or a stray high-order write shows up as a list mismatch. Directed blocks hit block-size codes 8 and 9 and each reserved bit alone, which separates an off-by-one limit from a missed reserved-bit check. They also cover a read-only flag combined with an illegal code, which separates the order of the checks. A long ready stall and a second start during a run show that the strobe waits for `bus_rdy` and that the captured block cannot be disturbed.

// File: rtl/ata_tf_pkg.sv
// Shared types and the slot schedule for the taskfile write sequencer.
// Assumes the command block layout given in the brief; the slot order
// below is the write order on the register port.
package ata_tf_pkg;

    localparam int BYTE_W   = 8;
    localparam int REG_AW   = 3;
    localparam int NREG     = 10;   // bytes 6..15 of the command block
    localparam int NSLOT    = 12;   // pre-dev, feat, 4 hob, 4 lob, cmd, post-dev

    localparam logic [REG_AW-1:0] RA_FEAT = 3'd1;
    localparam logic [REG_AW-1:0] RA_SCNT = 3'd2;
    localparam logic [REG_AW-1:0] RA_DEV  = 3'd6;
    localparam logic [REG_AW-1:0] RA_CMD  = 3'd7;

    typedef struct packed {
        logic [3:0]                   blk_log2;
        logic [2:0]                   rsvd;
        logic                         ext48;
        logic                         dev_after;
        logic                         rd_only;
        logic                         dev_from_cb;
        logic [BYTE_W-1:0]            dev_cb;
        logic [NREG-1:0][BYTE_W-1:0]  regs;   // [0]=features .. [9]=command
    } cb_fields_t;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] addr;
        logic [BYTE_W-1:0] data;
    } slot_t;

    // Describe write slot idx for a decoded block and resolved device/head byte.
    function automatic slot_t slot_of(input int idx, input cb_fields_t f,
                                      input logic [BYTE_W-1:0] devhead);
        slot_t s;
        s = '0;
        if (idx == 0) begin
            s.en = !f.dev_after; s.addr = RA_DEV; s.data = devhead;
        end else if (idx == 1) begin
            s.en = 1'b1; s.addr = RA_FEAT; s.data = f.regs[0];
        end else if (idx >= 2 && idx <= 5) begin
            s.en = f.ext48; s.addr = RA_SCNT + REG_AW'(idx - 2); s.data = f.regs[idx - 1];
        end else if (idx >= 6 && idx <= 9) begin
            s.en = 1'b1; s.addr = RA_SCNT + REG_AW'(idx - 6); s.data = f.regs[idx - 1];
        end else if (idx == 10) begin
            s.en = 1'b1; s.addr = RA_CMD; s.data = f.regs[9];
        end else begin
            s.en = f.dev_after; s.addr = RA_DEV; s.data = devhead;
        end
        return s;
    endfunction

endpackage

// File: rtl/ata_cb_decode.sv
// Field extraction and validation of a captured command block.
// Assumes the block is held stable by the caller; purely combinational.
module ata_cb_decode
    import ata_tf_pkg::*;
#(
    parameter int CB_BYTES     = 16,
    parameter int MAX_BLK_LOG2 = 8
) (
    input  logic [CB_BYTES*BYTE_W-1:0] cb,
    input  logic [BYTE_W-1:0]          own_dev,
    output cb_fields_t                 fields,
    output logic [BYTE_W-1:0]          devhead,
    output logic                       legal
);

    localparam int B_SEL  = 2;
    localparam int B_ACT  = 3;
    localparam int B_CNT  = 4;
    localparam int B_DEV  = 5;
    localparam int B_REG0 = 6;

    // Pull each control field and register byte out of the flat block.
    always_comb begin
        fields.dev_from_cb = cb[B_SEL*BYTE_W + 6];
        fields.rd_only     = cb[B_ACT*BYTE_W + 0];
        fields.dev_after   = cb[B_ACT*BYTE_W + 1];
        fields.ext48       = cb[B_CNT*BYTE_W + 0];
        fields.rsvd        = cb[B_CNT*BYTE_W + 1 +: 3];
        fields.blk_log2    = cb[B_CNT*BYTE_W + 4 +: 4];
        fields.dev_cb      = cb[B_DEV*BYTE_W +: BYTE_W];
        for (int k = 0; k < NREG; k++) begin
            fields.regs[k] = cb[(B_REG0 + k)*BYTE_W +: BYTE_W];
        end
    end

    // Choose the device/head source and judge the block legal or not.
    always_comb begin
        devhead = fields.dev_from_cb ? fields.dev_cb : own_dev;
        legal   = (int'(fields.blk_log2) <= MAX_BLK_LOG2) && (fields.rsvd == '0);
    end

endmodule

// File: rtl/ata_slot_table.sv
// Expands decoded fields into the fixed table of candidate writes.
// Assumes inputs are stable while the engine walks the table.
module ata_slot_table
    import ata_tf_pkg::*;
#(
    parameter int N = NSLOT
) (
    input  cb_fields_t         fields,
    input  logic [BYTE_W-1:0]  devhead,
    output slot_t [N-1:0]      slots
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        // One table entry per write position.
        always_comb slots[i] = slot_of(i, fields, devhead);
    end

endmodule

// File: rtl/ata_wr_engine.sv
// Control FSM: accepts start, routes fail / handoff, then walks the slot
// table issuing one ready-gated strobe per enabled slot, then pulses done.
// Assumes legal/rd_only/slots are valid from the cycle after capture.
module ata_wr_engine
    import ata_tf_pkg::*;
#(
    parameter int N = NSLOT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               bus_rdy,
    input  logic               legal,
    input  logic               rd_only,
    input  slot_t [N-1:0]      slots,
    output logic               capture,
    output logic [REG_AW-1:0]  bus_addr,
    output logic [BYTE_W-1:0]  bus_data,
    output logic               bus_wr,
    output logic               done,
    output logic               fail,
    output logic               handoff
);

    localparam int IW = $clog2(N + 1);
    localparam logic [IW-1:0] END_IDX = IW'(N);

    typedef enum logic [1:0] {S_IDLE, S_DECIDE, S_ISSUE, S_STROBE} st_t;

    st_t           st;
    logic [IW-1:0] idx;
    slot_t         cur;

    // Current table entry; the end index never selects an entry.
    always_comb cur = (idx < END_IDX) ? slots[idx] : '0;

    // Capture request for the block register, only when idle.
    always_comb capture = (st == S_IDLE) && start;

    // Sequencing state, strobe and outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            idx      <= '0;
            bus_addr <= '0;
            bus_data <= '0;
            bus_wr   <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
            handoff  <= 1'b0;
        end else begin
            bus_wr  <= 1'b0;
            done    <= 1'b0;
            fail    <= 1'b0;
            handoff <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) st <= S_DECIDE;
                end
                S_DECIDE: begin
                    idx <= '0;
                    if (!legal) begin
                        fail <= 1'b1;
                        st   <= S_IDLE;
                    end else if (rd_only) begin
                        handoff <= 1'b1;
                        st      <= S_IDLE;
                    end else begin
                        st <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (idx == END_IDX) begin
                        done <= 1'b1;
                        st   <= S_IDLE;
                    end else if (!cur.en) begin
                        idx <= idx + 1'b1;
                    end else if (bus_rdy) begin
                        bus_wr   <= 1'b1;
                        bus_addr <= cur.addr;
                        bus_data <= cur.data;
                        st       <= S_STROBE;
                    end
                end
                default: begin
                    idx <= idx + 1'b1;
                    st  <= S_ISSUE;
                end
            endcase
        end
    end

endmodule

// File: rtl/ata_tf_seq.sv
// Top of the taskfile write sequencer: captures the command block on an
// accepted start and wires decode, slot table and write engine together.
// Assumes a single register port with a ready input and no back-pressure
// beyond it.
module ata_tf_seq
    import ata_tf_pkg::*;
#(
    parameter int CB_BYTES     = 16,
    parameter int MAX_BLK_LOG2 = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CB_BYTES*8-1:0]      cmd_blk,
    input  logic [7:0]                 own_devhead,
    input  logic                       bus_rdy,
    output logic [2:0]                 bus_addr,
    output logic [7:0]                 bus_data,
    output logic                       bus_wr,
    output logic                       done,
    output logic                       fail,
    output logic                       handoff
);

    logic [CB_BYTES*8-1:0] cb_q;
    logic [7:0]            own_q;
    logic                  capture;
    cb_fields_t            fields;
    logic [7:0]            devhead;
    logic                  legal;
    slot_t [NSLOT-1:0]     slots;

    // Hold the command block and bridge device/head value for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cb_q  <= '0;
            own_q <= '0;
        end else if (capture) begin
            cb_q  <= cmd_blk;
            own_q <= own_devhead;
        end
    end

    ata_cb_decode #(.CB_BYTES(CB_BYTES), .MAX_BLK_LOG2(MAX_BLK_LOG2)) u_dec (
        .cb      (cb_q),
        .own_dev (own_q),
        .fields  (fields),
        .devhead (devhead),
        .legal   (legal)
    );

    ata_slot_table #(.N(NSLOT)) u_tab (
        .fields  (fields),
        .devhead (devhead),
        .slots   (slots)
    );

    ata_wr_engine #(.N(NSLOT)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bus_rdy  (bus_rdy),
        .legal    (legal),
        .rd_only  (fields.rd_only),
        .slots    (slots),
        .capture  (capture),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .bus_wr   (bus_wr),
        .done     (done),
        .fail     (fail),
        .handoff  (handoff)
    );

endmodule

// File: rtl/ata_tf_seq_chk.sv
// Port-level protocol checker for ata_tf_seq, attached by bind.
module ata_tf_seq_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [127:0] cmd_blk,
    input logic [7:0]   own_devhead,
    input logic         bus_rdy,
    input logic [2:0]   bus_addr,
    input logic [7:0]   bus_data,
    input logic         bus_wr,
    input logic         done,
    input logic         fail,
    input logic         handoff
);

    logic wr_seen;
    logic cmd_seen;

    // Track writes and command-register writes since the last outcome pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen  <= 1'b0;
            cmd_seen <= 1'b0;
        end else if (done || fail || handoff) begin
            wr_seen  <= 1'b0;
            cmd_seen <= 1'b0;
        end else if (bus_wr) begin
            wr_seen  <= 1'b1;
            if (bus_addr == 3'd7) cmd_seen <= 1'b1;
        end
    end

    p_strobe_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);

    p_strobe_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> $past(bus_rdy));

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail, handoff}));

    p_outcome_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail || handoff) |=> !(done || fail || handoff));

    p_no_wr_with_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail || handoff) |-> !bus_wr);

    p_fail_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !wr_seen);

    p_handoff_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |-> !wr_seen);

    p_done_after_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_seen);

    p_only_dev_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cmd_seen) |-> (bus_addr == 3'd6));

endmodule

bind ata_tf_seq ata_tf_seq_chk u_chk (.*);

// File: tb/ata_tf_seq_bench.sv
module ata_tf_seq_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] cmd_blk = '0;
    logic [7:0]   own_devhead = '0;
    logic         bus_rdy = 1'b0;
    logic [2:0]   bus_addr;
    logic [7:0]   bus_data;
    logic         bus_wr;
    logic         done, fail, handoff;

    int checks = 0;
    int bad    = 0;
    int cycles = 0;

    // Monitor state
    logic [2:0] got_addr [0:31];
    logic [7:0] got_data [0:31];
    int  got_n = 0, done_n = 0, fail_n = 0, ho_n = 0, r8_bad = 0;
    logic prev_wr = 1'b0;
    int  rdy_mode = 0;   // 0 random, 1 low, 2 high

    // Expected values
    logic [2:0] exp_addr [0:15];
    logic [7:0] exp_data [0:15];
    int  exp_n = 0;
    int  exp_out = 0;    // 1 done, 2 fail, 3 handoff

    always #2 clk = ~clk;   // 250 MHz

    ata_tf_seq u_ata_tf_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_blk(cmd_blk),
        .own_devhead(own_devhead), .bus_rdy(bus_rdy), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_wr(bus_wr), .done(done), .fail(fail),
        .handoff(handoff)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad++; checks++;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // Sample outputs and drive ready away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_wr) begin
                if (got_n < 32) begin
                    got_addr[got_n] = bus_addr;
                    got_data[got_n] = bus_data;
                end
                got_n++;
                if (!bus_rdy) r8_bad++;
                if (prev_wr) r8_bad++;
            end
            prev_wr = bus_wr;
            if (done) done_n++;
            if (fail) fail_n++;
            if (handoff) ho_n++;
        end
        case (rdy_mode)
            1:       bus_rdy = 1'b0;
            2:       bus_rdy = 1'b1;
            default: bus_rdy = ($urandom % 4) != 0;
        endcase
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input logic [2:0] a, input logic [7:0] d);
        exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
    endtask

    // Expected outcome and write list from the requirements.
    task automatic calc_exp(input logic [127:0] cb, input logic [7:0] own);
        logic [7:0] dev;
        exp_n = 0;
        dev = cb[22] ? cb[47:40] : own;                         // R7
        if (cb[39:36] > 4'd8 || cb[35:33] != 3'd0) exp_out = 2; // R1 R2
        else if (cb[24]) exp_out = 3;                           // R3
        else begin
            exp_out = 1;
            if (!cb[25]) push(3'd6, dev);                       // R6
            push(3'd1, cb[55:48]);                              // R4
            if (cb[32])                                         // R5
                for (int k = 0; k < 4; k++) push(3'(2 + k), cb[(7 + k)*8 +: 8]);
            for (int k = 0; k < 4; k++) push(3'(2 + k), cb[(11 + k)*8 +: 8]);
            push(3'd7, cb[127:120]);
            if (cb[25]) push(3'd6, dev);
        end
    endtask

    // Run one command and compare against expectations.
    task automatic run_cmd(input logic [127:0] cb, input logic [7:0] own, input string tag,
                           input int stall, input bit dbl);
        int   wait_n;
        int   mism;
        int   save_mode;
        calc_exp(cb, own);
        got_n = 0; done_n = 0; fail_n = 0; ho_n = 0; r8_bad = 0;
        @(negedge clk);
        cmd_blk = cb; own_devhead = own; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd_blk = ~cb; own_devhead = ~own;     // R10: later changes ignored
        if (stall > 0) begin
            save_mode = rdy_mode;
            rdy_mode = 1;
            repeat (stall) @(negedge clk);
            check(got_n == 0, "R8 no strobe while ready low", got_n, 0);
            rdy_mode = save_mode;
        end
        if (dbl) begin
            repeat (2) @(negedge clk);
            cmd_blk = {cb[127:40], 8'h90, cb[31:0]};
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_n = 0;
        while (done_n + fail_n + ho_n == 0 && wait_n < 2000) begin
            @(negedge clk); wait_n++;
        end
        repeat (6) @(negedge clk);
        check(wait_n < 2000, {tag, " R9 outcome seen"}, wait_n, 0);
        check(done_n == (exp_out == 1) && fail_n == (exp_out == 2) && ho_n == (exp_out == 3),
              {tag, " R9 outcome kind"}, done_n*100 + fail_n*10 + ho_n,
              (exp_out == 1)*100 + (exp_out == 2)*10 + (exp_out == 3));
        check(got_n == exp_n, {tag, " write count"}, got_n, exp_n);
        mism = -1;
        for (int k = 0; k < exp_n && k < got_n; k++)
            if (mism < 0 && (got_addr[k] != exp_addr[k] || got_data[k] != exp_data[k])) mism = k;
        if (mism >= 0)
            check(1'b0, {tag, " write list"}, {got_addr[mism], got_data[mism]},
                  {exp_addr[mism], exp_data[mism]});
        else
            check(1'b1, {tag, " write list"}, 0, 0);
        check(r8_bad == 0, "R8 strobe gated and single", r8_bad, 0);
    endtask

    function automatic logic [127:0] mk(input logic [3:0] blk, input logic [2:0] rsv,
                                        input bit e48, input bit after, input bit rdo,
                                        input bit dsel);
        logic [127:0] c;
        for (int k = 0; k < 16; k++) c[k*8 +: 8] = 8'(8'h10 * k + 8'h3 + k);
        c[22] = dsel; c[24] = rdo; c[25] = after;
        c[32] = e48; c[35:33] = rsv; c[39:36] = blk;
        return c;
    endfunction

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        check(!bus_wr && !done && !fail && !handoff && bus_addr == 0 && bus_data == 0,
              "R11 outputs low in reset", {bus_wr, done, fail, handoff}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_wr && !done && !fail && !handoff, "R11 outputs low after reset",
              {bus_wr, done, fail, handoff}, 0);

        // Directed corners
        rdy_mode = 2;
        run_cmd(mk(4'd0, 3'd0, 0, 0, 0, 0), 8'hA5, "R4 basic", 0, 0);
        run_cmd(mk(4'd8, 3'd0, 1, 0, 0, 1), 8'hA5, "R5 R7 ext48 cb-dev", 0, 0);
        run_cmd(mk(4'd3, 3'd0, 0, 1, 0, 0), 8'h5A, "R6 dev after", 0, 0);
        run_cmd(mk(4'd9, 3'd0, 1, 0, 0, 0), 8'h11, "R1 code 9", 0, 0);
        run_cmd(mk(4'd15, 3'd0, 0, 0, 0, 0), 8'h11, "R1 code 15", 0, 0);
        for (int b = 0; b < 3; b++)
            run_cmd(mk(4'd1, 3'(1 << b), 0, 0, 0, 0), 8'h22, "R2 reserved bit", 0, 0);
        run_cmd(mk(4'd2, 3'd0, 0, 0, 1, 0), 8'h33, "R3 read only", 0, 0);
        run_cmd(mk(4'd12, 3'd0, 0, 0, 1, 0), 8'h33, "R1 R3 fault beats read only", 0, 0);
        rdy_mode = 0;
        run_cmd(mk(4'd4, 3'd0, 1, 1, 0, 1), 8'h44, "R8 stall", 25, 0);
        run_cmd(mk(4'd5, 3'd0, 1, 0, 0, 0), 8'h66, "R10 start while busy", 0, 1);

        // Constrained random
        for (int n = 0; n < 150; n++) begin
            logic [127:0] c;
            c = {$urandom, $urandom, $urandom, $urandom};
            c[39:36] = (($urandom % 8) == 0) ? 4'($urandom) : 4'($urandom % 9);
            c[35:33] = (($urandom % 10) == 0) ? 3'($urandom) : 3'd0;
            c[24]    = (($urandom % 8) == 0);
            rdy_mode = int'($urandom % 3 != 0 ? 0 : 2);
            run_cmd(c, 8'($urandom), "R4 R5 R6 R7 random", 0, 0);
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule